// File: doc/BRIEF.md
# Byte-Lane Masked Word Memory

This block is a small synchronous storage array that is 32 bits wide and addressed in bytes. A caller supplies a byte address, and the block drops the two low address bits to pick a word. A 4-bit lane mask goes with each access. Each mask bit controls one 8-bit lane of the word. On a write, only the enabled lanes are stored. On a read, only the enabled lanes are returned, and every other lane reads as zero.

Every access is one clock cycle long. The read data is registered, so the value for an access appears after the rising edge that samples its address and mask. A write and a read to the same word in the same cycle return the contents from before that write. An active-high synchronous reset clears every word and the output register, so the memory starts from all zeros.

Top module: `lane_word_mem`

## Requirements
- R1: While reset is high at a rising edge, every stored word and the read output are cleared to zero. After reset, any read returns zero until that word is written.
- R2: The word index is address bits [ADDR_W-1:2]. The two low address bits have no effect on which word is written or read, so byte addresses 0x04..0x07 all select the second word.
- R3: At a rising edge with write enable high, each lane whose mask bit is set takes its byte from the write data. The mapping is: mask bit 0 to bits 7:0, bit 1 to bits 15:8, bit 2 to bits 23:16, bit 3 to bits 31:24.
- R4: A lane whose mask bit is clear keeps its old value during a write. When write enable is low, no word changes.
- R5: At each rising edge, the read output is loaded with the addressed word ANDed lane by lane with the mask. A lane whose mask bit is clear reads as zero.
- R6: A read in the same cycle as a write to the same word returns the contents from before the write. The new value is seen from the following access on.
- R7: To store one byte into the top lane, place it on write-data bits 31:24 and set the mask to 4'b1000. The lower three lanes are left untouched.
- R8: Different words are independent. A write to one word never alters any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears storage and output |
| wr_en | input | 1 | Write enable for the current access |
| byte_addr | input | ADDR_W | Byte address; bits above bit 1 pick the word |
| lane_sel | input | 4 | Per-lane enable for both write and read |
| wr_data | input | 32 | Write data, lane n on bits 8n+7:8n |
| rd_data | output | 32 | Registered masked read data |

## Verification
The bench builds the block with ADDR_W set to 6, which gives 16 words. With so few words, random addresses hit the same word again and again. That brings partial-lane merges, same-cycle read and write collisions, and aliasing of the low address bits within reach in a few hundred operations. Directed cases add checks after reset, single-lane writes into each lane and the top lane, idle cycles with write enable low, and isolation between word 0 and word 1. A bench model predicts every read from the lane rules alone.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int LOW_BITS = $clog2(LANES);

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic       we;
        lane_mask_t lanes;
        word_t      data;
    } wr_req_t;

    function automatic word_t expand_lanes(lane_mask_t m);
        word_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        end
        return r;
    endfunction
endpackage

// File: rtl/lwm_lane_expand.sv
module lwm_lane_expand
    import lwm_pkg::*;
(
    input  lane_mask_t lanes,
    output word_t      bit_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{lanes[g]}};
    end
endmodule

// File: rtl/lwm_bank.sv
module lwm_bank
    import lwm_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic [IDX_W-1:0] idx,
    output word_t            old_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WORDS; w++) begin
                    store[w] <= '0;
                end
            end else if (req.we && req.lanes[g]) begin
                store[idx] <= req.data[g*LANE_W +: LANE_W];
            end
        end

        assign old_word[g*LANE_W +: LANE_W] = store[idx];
    end
endmodule

// File: rtl/lwm_read_reg.sv
module lwm_read_reg
    import lwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t raw_word,
    input  word_t bit_mask,
    output word_t rd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= raw_word & bit_mask;
        end
    end
endmodule

// File: rtl/lane_word_mem.sv
module lane_word_mem
    import lwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - LOW_BITS,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    wr_req_t          req;
    logic [IDX_W-1:0] word_idx;
    word_t            bit_mask;
    word_t            old_word;

    assign word_idx  = byte_addr[ADDR_W-1:LOW_BITS];
    assign req.we    = wr_en;
    assign req.lanes = lane_sel;
    assign req.data  = wr_data;

    lwm_lane_expand u_expand (
        .lanes    (lane_sel),
        .bit_mask (bit_mask)
    );

    lwm_bank #(.WORDS(WORDS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .idx      (word_idx),
        .old_word (old_word)
    );

    lwm_read_reg u_rd (
        .clk      (clk),
        .rst      (rst),
        .raw_word (old_word),
        .bit_mask (bit_mask),
        .rd_q     (rd_data)
    );
endmodule

// File: rtl/lwm_chk.sv
module lwm_chk
    import lwm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] byte_addr,
    input logic [LANES-1:0]  lane_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data
);
    AST_RESET_CLEARS_OUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == '0);  // R1

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        AST_MASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !$past(lane_sel[g]) |-> rd_data[g*LANE_W +: LANE_W] == '0);  // R5
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($stable(byte_addr[ADDR_W-1:LOW_BITS]) && $stable(lane_sel) && !$past(wr_en) && !$past(rst))
        |=> $stable(rd_data));  // R4

    AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en, 2) && $past(lane_sel, 2) == 4'hF && $past(lane_sel) == 4'hF
         && $past(byte_addr[ADDR_W-1:LOW_BITS]) == $past(byte_addr[ADDR_W-1:LOW_BITS], 2)
         && !$past(rst) && !$past(rst, 2))
        |-> rd_data == $past(wr_data, 2));  // R3
endmodule

bind lane_word_mem lwm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .byte_addr (byte_addr),
    .lane_sel  (lane_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
);

// File: tb/lane_word_mem_tb.sv
module lane_word_mem_tb;
    localparam int AW = 6;
    localparam int NW = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [AW-1:0] byte_addr;
    logic [3:0]    lane_sel;
    logic [31:0]   wr_data;
    logic [31:0]   rd_data;

    logic [31:0] model [NW];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    lane_word_mem #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .byte_addr(byte_addr),
        .lane_sel(lane_sel), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [31:0] lanes_of(logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // one access: drive after a falling edge, let a rising edge pass, compare at the next falling edge
    task automatic access(string req, logic we, logic [AW-1:0] a, logic [3:0] s, logic [31:0] d);
        logic [31:0] exp;
        int w;
        w = int'(a >> 2);
        exp = model[w] & lanes_of(s);
        wr_en = we; byte_addr = a; lane_sel = s; wr_data = d;
        if (we) model[w] = (model[w] & ~lanes_of(s)) | (d & lanes_of(s));
        @(posedge clk);
        @(negedge clk);
        check(req, rd_data, exp);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NW; i++) model[i] = '0;
        rst = 1'b1; wr_en = 1'b0; byte_addr = '0; lane_sel = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset output", rd_data, 32'h0);
        rst = 1'b0;
        for (int i = 0; i < NW; i++) access("R1 zero after reset", 1'b0, AW'(i * 4), 4'hF, 32'hFFFF_FFFF);

        // R3 each lane alone into word 2
        access("R3 lane0", 1'b1, 6'h08, 4'b0001, 32'hA1B2_C3D4);
        access("R3 lane1", 1'b1, 6'h08, 4'b0010, 32'h1122_3344);
        access("R3 lane2", 1'b1, 6'h08, 4'b0100, 32'h5566_7788);
        access("R3 merged read", 1'b0, 6'h08, 4'hF, 32'h0);
        // R7 top lane
        access("R7 top lane write", 1'b1, 6'h08, 4'b1000, 32'hF1EE_EEEE);
        access("R7 top lane read", 1'b0, 6'h08, 4'hF, 32'h0);
        // R4 mask-off lanes untouched, idle write ignored
        access("R4 partial write", 1'b1, 6'h08, 4'b0101, 32'h0000_0000);
        access("R4 idle no change", 1'b0, 6'h08, 4'hF, 32'hDEAD_BEEF);
        access("R4 idle confirm", 1'b0, 6'h08, 4'hF, 32'h0);
        // R2 low bits ignored
        access("R2 write via offset 3", 1'b1, 6'h07, 4'hF, 32'hCAFE_0001);
        access("R2 read via offset 1", 1'b0, 6'h05, 4'hF, 32'h0);
        access("R2 read via offset 2", 1'b0, 6'h06, 4'hF, 32'h0);
        // R8 word 0 and word 1 independent
        access("R8 word0 write", 1'b1, 6'h00, 4'hF, 32'h0BAD_F00D);
        access("R8 word1 intact", 1'b0, 6'h04, 4'hF, 32'h0);
        access("R8 word0 read", 1'b0, 6'h00, 4'hF, 32'h0);
        // R5 masked reads
        access("R5 mask 1010", 1'b0, 6'h00, 4'b1010, 32'h0);
        access("R5 mask 0000", 1'b0, 6'h00, 4'b0000, 32'h0);
        // R6 read during write returns old contents
        access("R6 collide", 1'b1, 6'h00, 4'hF, 32'h1357_9BDF);
        access("R6 after collide", 1'b0, 6'h00, 4'hF, 32'h0);

        for (int i = 0; i < 600; i++) begin
            access("R3/R4/R5/R6 random", 1'($urandom), AW'($urandom), 4'($urandom), $urandom);
        end

        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = '0;
        for (int i = 0; i < NW; i++) access("R1 cleared by reset", 1'b0, AW'(i * 4), 4'hF, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule